// File: doc/BRIEF.md
# Cache Line Zeroing Store Engine

This block executes the two block-clear instructions of a 32-bit big-endian instruction set: a short form that zeroes a 32-byte line and a long form that zeroes a 128-byte line. A start pulse presents the instruction word. The block drives the two operand indices to a combinational register-file read port and forms the effective address from the returned values. It forces that address down to the line boundary and then streams zero words to memory over a ready/valid write port.

Before the first write, the block can emit a single-cycle strobe with the line address. This strobe lets a load-reserve tracker drop any reservation on that line. The block never reads memory and never writes a register or status flag. A done pulse tells the fetch logic to step the program counter by 4. An instruction word that matches neither form raises a one-cycle illegal flag and issues no writes.

Top module: `zline_engine`

## Requirements
- R1: With the register fields (word bits 20:11, LSB-0 numbering) masked off, a word equal to 0x7C0007EC is the 32-byte form and a word equal to 0x7C2007EC is the 128-byte form. The base register index is bits 20:16 and the offset register index is bits 15:11.
- R2: The effective address is base plus the offset register value, modulo 2^32. The base is the constant zero when the base index is 0, and the register value otherwise.
- R3: The line address is the effective address with its low 5 bits cleared (32-byte form) or its low 7 bits cleared (128-byte form). A misaligned address never raises an error.
- R4: The 32-byte form issues exactly 8 word writes and the 128-byte form exactly 32. The writes start at the line address and rise by 4 per accepted handshake.
- R5: Every write carries data 0 and byte enables 4'b1111.
- R6: While wr_ready_i is low, a pending write keeps wr_valid_o high and wr_addr_o unchanged.
- R7: The invalidate strobe is raised only if both resv_en_i and resv_active_i are high when the start is taken. It lasts one cycle, carries the line address, and comes before the first write.
- R8: A start with an unrecognised word raises illegal_o in the next cycle for one cycle, issues no write and leaves busy_o low.
- R9: busy_o rises in the cycle after an accepted start and stays high through the done cycle. A start while busy_o is high is ignored.
- R10: done_o pulses for one cycle after the last write is accepted, once per legal instruction, and busy_o is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Instruction start pulse |
| insn_i | input | 32 | Instruction word, valid with start_i |
| gpr_ra_idx_o | output | 5 | Base register index to register file |
| gpr_rb_idx_o | output | 5 | Offset register index to register file |
| gpr_ra_data_i | input | 32 | Base register value (combinational read) |
| gpr_rb_data_i | input | 32 | Offset register value (combinational read) |
| resv_en_i | input | 1 | Reservation tracking enabled |
| resv_active_i | input | 1 | A reservation is currently held |
| inval_o | output | 1 | Reservation invalidate strobe |
| inval_addr_o | output | 32 | Line address for the invalidate |
| wr_valid_o | output | 1 | Memory write request |
| wr_ready_i | input | 1 | Memory accepts the write |
| wr_addr_o | output | 32 | Write byte address |
| wr_data_o | output | 32 | Write data (always zero) |
| wr_be_o | output | 4 | Byte enables |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Completion pulse, PC advances by 4 |
| illegal_o | output | 1 | Unrecognised instruction pulse |

## Verification
The hardest situation to reach is a second start arriving in the middle of a stalled burst, combined with a line boundary that lies below the raw address. In that situation a stray accepted start or a wrong mask would shift or duplicate words.

The bench sweeps both forms across many base/offset pairs, including sums that wrap past 2^32. It throttles wr_ready_i with a pseudo-random pattern, and in half the runs it injects a second start a few cycles into the burst. It then compares the full logged write sequence, including length, against the arithmetic line address.

// File: rtl/zc_pkg.sv
package zc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INVAL = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } zc_state_e;

  // register fields cleared before matching
  localparam logic [31:0] FIELD_MASK = 32'hFFE0_07FF;
  localparam logic [31:0] FORM_SHORT = 32'h7C00_07EC;
  localparam logic [31:0] FORM_LONG  = 32'h7C20_07EC;
endpackage

// File: rtl/zc_decode.sv
module zc_decode
  import zc_pkg::*;
(
  input  logic [31:0] insn_i,
  output logic        short_o,
  output logic        long_o,
  output logic [4:0]  ra_idx_o,
  output logic [4:0]  rb_idx_o
);
  logic [31:0] masked;

  always_comb begin
    masked   = insn_i & FIELD_MASK;
    short_o  = (masked == FORM_SHORT);
    long_o   = (masked == FORM_LONG);
    ra_idx_o = insn_i[20:16];
    rb_idx_o = insn_i[15:11];
  end
endmodule

// File: rtl/zc_agen.sv
module zc_agen #(
  parameter int ADDR_W      = 32,
  parameter int SHORT_BYTES = 32,
  parameter int LONG_BYTES  = 128
) (
  input  logic [4:0]        ra_idx_i,
  input  logic [ADDR_W-1:0] ra_data_i,
  input  logic [ADDR_W-1:0] rb_data_i,
  input  logic              long_i,
  output logic [ADDR_W-1:0] line_o
);
  localparam logic [ADDR_W-1:0] SHORT_OFS = ADDR_W'(SHORT_BYTES - 1);
  localparam logic [ADDR_W-1:0] LONG_OFS  = ADDR_W'(LONG_BYTES - 1);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] ea;

  always_comb begin
    base   = (ra_idx_i == 5'd0) ? '0 : ra_data_i;
    ea     = base + rb_data_i;
    line_o = ea & ~(long_i ? LONG_OFS : SHORT_OFS);
  end
endmodule

// File: rtl/zc_burst.sv
module zc_burst
  import zc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SHORT_WORDS = 8,
  parameter int LONG_WORDS  = 32,
  parameter int WORD_BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              legal_i,
  input  logic              long_i,
  input  logic [ADDR_W-1:0] line_i,
  input  logic              resv_hit_i,
  input  logic              wr_ready_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              illegal_o,
  output logic              inval_o,
  output logic [ADDR_W-1:0] inval_addr_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o
);
  localparam int CNT_W = $clog2(LONG_WORDS);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_WORDS - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_WORDS - 1);
  localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(WORD_BYTES);

  zc_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q, line_q;
  logic [CNT_W-1:0]  idx_q;
  logic              long_q;
  logic              illegal_q, illegal_d;
  logic              load_en, step_en, accept, last;

  always_comb begin
    state_d   = state_q;
    load_en   = 1'b0;
    step_en   = 1'b0;
    accept    = (state_q == ST_IDLE) && start_i;
    illegal_d = accept && !legal_i;
    last      = (idx_q == (long_q ? LONG_LAST : SHORT_LAST));
    unique case (state_q)
      ST_IDLE: begin
        if (accept && legal_i) begin
          load_en = 1'b1;
          state_d = resv_hit_i ? ST_INVAL : ST_WRITE;
        end
      end
      ST_INVAL: state_d = ST_WRITE;
      ST_WRITE: begin
        if (wr_ready_i) begin
          step_en = 1'b1;
          if (last) state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      illegal_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      illegal_q <= illegal_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      line_q <= '0;
      idx_q  <= '0;
      long_q <= 1'b0;
    end else if (load_en) begin
      addr_q <= line_i;
      line_q <= line_i;
      idx_q  <= '0;
      long_q <= long_i;
    end else if (step_en) begin
      addr_q <= addr_q + STEP;
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = (state_q == ST_DONE);
  assign inval_o      = (state_q == ST_INVAL);
  assign wr_valid_o   = (state_q == ST_WRITE);
  assign wr_addr_o    = addr_q;
  assign inval_addr_o = line_q;
  assign illegal_o    = illegal_q;
endmodule

// File: rtl/zline_engine.sv
module zline_engine #(
  parameter int ADDR_W      = 32,
  parameter int SHORT_BYTES = 32,
  parameter int LONG_BYTES  = 128,
  parameter int WORD_BYTES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [31:0]             insn_i,
  output logic [4:0]              gpr_ra_idx_o,
  output logic [4:0]              gpr_rb_idx_o,
  input  logic [ADDR_W-1:0]       gpr_ra_data_i,
  input  logic [ADDR_W-1:0]       gpr_rb_data_i,
  input  logic                    resv_en_i,
  input  logic                    resv_active_i,
  output logic                    inval_o,
  output logic [ADDR_W-1:0]       inval_addr_o,
  output logic                    wr_valid_o,
  input  logic                    wr_ready_i,
  output logic [ADDR_W-1:0]       wr_addr_o,
  output logic [8*WORD_BYTES-1:0] wr_data_o,
  output logic [WORD_BYTES-1:0]   wr_be_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    illegal_o
);
  localparam int SHORT_WORDS = SHORT_BYTES / WORD_BYTES;
  localparam int LONG_WORDS  = LONG_BYTES / WORD_BYTES;

  logic              is_short, is_long;
  logic [ADDR_W-1:0] line_addr;

  zc_decode u_dec (
    .insn_i   (insn_i),
    .short_o  (is_short),
    .long_o   (is_long),
    .ra_idx_o (gpr_ra_idx_o),
    .rb_idx_o (gpr_rb_idx_o)
  );

  zc_agen #(
    .ADDR_W(ADDR_W), .SHORT_BYTES(SHORT_BYTES), .LONG_BYTES(LONG_BYTES)
  ) u_agen (
    .ra_idx_i  (gpr_ra_idx_o),
    .ra_data_i (gpr_ra_data_i),
    .rb_data_i (gpr_rb_data_i),
    .long_i    (is_long),
    .line_o    (line_addr)
  );

  zc_burst #(
    .ADDR_W(ADDR_W), .SHORT_WORDS(SHORT_WORDS),
    .LONG_WORDS(LONG_WORDS), .WORD_BYTES(WORD_BYTES)
  ) u_burst (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .legal_i      (is_short | is_long),
    .long_i       (is_long),
    .line_i       (line_addr),
    .resv_hit_i   (resv_en_i & resv_active_i),
    .wr_ready_i   (wr_ready_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .illegal_o    (illegal_o),
    .inval_o      (inval_o),
    .inval_addr_o (inval_addr_o),
    .wr_valid_o   (wr_valid_o),
    .wr_addr_o    (wr_addr_o)
  );

  assign wr_data_o = '0;
  assign wr_be_o   = '1;
endmodule

// File: rtl/zc_chk.sv
module zc_chk #(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    inval_o,
  input logic [ADDR_W-1:0]       inval_addr_o,
  input logic                    wr_valid_o,
  input logic                    wr_ready_i,
  input logic [ADDR_W-1:0]       wr_addr_o,
  input logic [8*WORD_BYTES-1:0] wr_data_o,
  input logic [WORD_BYTES-1:0]   wr_be_o,
  input logic                    busy_o,
  input logic                    done_o,
  input logic                    illegal_o
);
  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o));

  // R4
  ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && wr_ready_i |=>
      !wr_valid_o || (wr_addr_o == $past(wr_addr_o) + ADDR_W'(WORD_BYTES)));

  // R5
  zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> (wr_data_o == '0) && (wr_be_o == '1));

  // R7
  inval_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inval_o |=> !inval_o && wr_valid_o);

  // R3
  inval_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inval_o |-> inval_addr_o[4:0] == 5'd0);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);

  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !busy_o && !wr_valid_o);

  // R9
  valid_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o || inval_o) |-> busy_o);
endmodule

bind zline_engine zc_chk #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .inval_o      (inval_o),
  .inval_addr_o (inval_addr_o),
  .wr_valid_o   (wr_valid_o),
  .wr_ready_i   (wr_ready_i),
  .wr_addr_o    (wr_addr_o),
  .wr_data_o    (wr_data_o),
  .wr_be_o      (wr_be_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .illegal_o    (illegal_o)
);

// File: tb/tb_zline_engine.sv
`timescale 1ns/1ps
module tb_zline_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [4:0]  ra_idx, rb_idx;
  logic [31:0] ra_data, rb_data;
  logic        resv_en = 1'b0, resv_act = 1'b0;
  logic        inval_o, wr_valid_o, busy_o, done_o, illegal_o;
  logic [31:0] inval_addr_o, wr_addr_o, wr_data_o;
  logic [3:0]  wr_be_o;
  logic        wr_ready = 1'b1;

  logic [31:0] regs [32];
  int tests = 0, fails = 0, cyc = 0;
  int wn = 0, bad_data = 0, inv_n = 0, done_n = 0, ill_n = 0;
  bit inv_early = 1'b0;
  logic [31:0] inv_addr_l = '0;
  logic [31:0] wlog [64];
  bit rdy_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  assign ra_data = regs[ra_idx];
  assign rb_data = regs[rb_idx];

  zline_engine dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .insn_i(insn_i),
    .gpr_ra_idx_o(ra_idx), .gpr_rb_idx_o(rb_idx),
    .gpr_ra_data_i(ra_data), .gpr_rb_data_i(rb_data),
    .resv_en_i(resv_en), .resv_active_i(resv_act),
    .inval_o(inval_o), .inval_addr_o(inval_addr_o),
    .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_be_o(wr_be_o),
    .busy_o(busy_o), .done_o(done_o), .illegal_o(illegal_o)
  );

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    wr_ready <= !rdy_mode || lfsr[0] || lfsr[5];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (wr_valid_o && wr_ready) begin
        if (wn < 64) wlog[wn] = wr_addr_o;
        if (wr_data_o != 0 || wr_be_o != 4'hF) bad_data = bad_data + 1;
        wn = wn + 1;
      end
      if (inval_o) begin
        inv_n = inv_n + 1;
        inv_addr_l = inval_addr_o;
        inv_early = (wn == 0);
      end
      if (done_o) done_n = done_n + 1;
      if (illegal_o) ill_n = ill_n + 1;
    end
  end

  task automatic summary_and_end();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc == 150000) begin
      tests = tests + 1;
      fails = fails + 1;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      summary_and_end();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    wn = 0; bad_data = 0; inv_n = 0; done_n = 0; ill_n = 0; inv_early = 1'b0;
  endtask

  task automatic run_op(input bit is_long, input logic [4:0] ra, input logic [4:0] rb,
                        input logic [31:0] rav, input logic [31:0] rbv,
                        input bit en, input bit act, input bit inject);
    logic [31:0] ea, line, base;
    int words, t, first_bad;
    regs[0] = 32'hDEAD_0000;
    if (ra != 0) regs[ra] = rav;
    regs[rb] = rbv;
    base  = (ra == 0) ? 32'h0 : rav;
    ea    = base + rbv;
    line  = is_long ? (ea & ~32'd127) : (ea & ~32'd31);
    words = is_long ? 32 : 8;
    @(negedge clk);
    clear_logs();
    resv_en = en; resv_act = act;
    insn_i  = (is_long ? 32'h7C20_07EC : 32'h7C00_07EC) | {11'd0, ra, rb, 11'd0};
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R9 busy after start", {31'd0, busy_o}, 32'd1);
    if (inject) begin
      @(negedge clk); @(negedge clk);
      insn_i  = 32'h7C20_07EC | {11'd0, 5'd3, 5'd4, 11'd0};
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    t = 0;
    while (done_n == 0 && t < 500) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
    chk(wn == words, "R4 write count", wn, words);
    first_bad = -1;
    for (int i = 0; i < words && i < wn; i++)
      if (first_bad < 0 && wlog[i] != line + 32'(4 * i)) first_bad = i;
    chk(first_bad < 0, is_long ? "R2/R3 long line addresses" : "R2/R3 short line addresses",
        (first_bad < 0) ? line : wlog[first_bad],
        (first_bad < 0) ? line : line + 32'(4 * first_bad));
    chk(bad_data == 0, "R5 zero data and full enables", bad_data, 0);
    if (en && act) begin
      chk(inv_n == 1 && inv_early, "R7 invalidate before writes", inv_n, 1);
      chk(inv_addr_l == line, "R7 invalidate address", inv_addr_l, line);
    end else begin
      chk(inv_n == 0, "R7 no invalidate", inv_n, 0);
    end
    chk(done_n == 1, "R10 single done", done_n, 1);
    chk(busy_o == 1'b0, "R9 idle after done", {31'd0, busy_o}, 32'd0);
  endtask

  task automatic run_illegal(input logic [31:0] w);
    @(negedge clk);
    clear_logs();
    insn_i = w; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(illegal_o == 1'b1 && busy_o == 1'b0, "R8 illegal flag", {30'd0, busy_o, illegal_o}, 32'd1);
    repeat (3) @(negedge clk);
    chk(ill_n == 1, "R8 illegal single pulse", ill_n, 1);
    chk(wn == 0 && done_n == 0, "R8 no writes", wn, 0);
    // R1: non-matching words are rejected
  endtask

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = 32'h0;
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && wr_valid_o == 0 && done_o == 0 && inval_o == 0 && illegal_o == 0,
        "R9 reset state", {27'd0, busy_o, wr_valid_o, done_o, inval_o, illegal_o}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 R3: worked example, literal-zero base
    run_op(1'b1, 5'd0, 5'd7, 32'h0, 32'h0001_0037, 1'b0, 1'b0, 1'b0);
    run_op(1'b0, 5'd0, 5'd7, 32'h0, 32'h0001_0037, 1'b1, 1'b1, 1'b0);
    // R2: wraparound of the sum
    run_op(1'b1, 5'd5, 5'd9, 32'hFFFF_FFF0, 32'h0000_00A3, 1'b1, 1'b1, 1'b0);

    // R6 R9: sweep both forms, bases, offsets, stalls and injected starts
    for (int k = 0; k < 64; k++) begin
      rdy_mode = k[3];
      run_op(k[0], k[1] ? 5'd5 : 5'd0, 5'd9,
             k[4] ? 32'hFFFF_FFC0 + 32'(k * 3) : 32'h0000_1000 + 32'(k * 24),
             32'h0001_0037 + 32'(k * 45), k[1], k[2], k[5]);
    end
    rdy_mode = 1'b0;

    run_illegal(32'h7C00_07ED);
    run_illegal(32'h7C40_07EC);
    run_illegal(32'h7C00_07E8);
    run_illegal(32'h0000_0000);

    summary_and_end();
  end
endmodule